// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 64-bit virtual address into a physical address by stepping through a four-level radix page table in memory. A client presents a virtual address on a valid/ready request port. The walker takes the top-level table's page number from a root input. It then reads one 64-bit entry per level over a single-outstanding memory port. Each entry read either yields the page number of the next table or, at the last level, the page number of the final 4 KB page.

The translated address is the final 40-bit page number with the untouched 12-bit page offset appended. It is returned on a valid/ready response port together with fault information. An address whose upper bits are not a proper sign extension is rejected at once, with no memory traffic. An entry whose present bit is clear ends the walk and reports the level at which it failed. The walker handles one translation at a time.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. It falls in the cycle after a request is accepted and stays low until the response handshake completes. While it is high, neither `mem_req_valid` nor `rsp_valid` is high.
- R2: The first table base is `root_ppn`, sampled in the acceptance cycle. Each entry address is the current base page number shifted left by 12, plus the 9-bit index times 8.
- R3: A successful walk issues exactly four reads, in this order: index bits [47:39] (top level), then [38:30], then [29:21], then [20:12].
- R4: In an entry, bit 0 is the present bit and bits [51:12] hold the 40-bit page number of the next table, or of the final page.
- R5: After a successful walk, `rsp_pa` equals the final page number concatenated with virtual address bits [11:0], and `rsp_fault` and `rsp_noncanon` are 0.
- R6: If bits [63:47] of the request are not all equal, the response carries `rsp_fault`=1, `rsp_noncanon`=1, `rsp_level`=3 and `rsp_pa`=0, and no memory read is issued.
- R7: A clear present bit ends the walk with `rsp_fault`=1, `rsp_noncanon`=0 and `rsp_pa`=0. `rsp_level` gives the failing level (3 = top, 2, 1, 0 = last), and no further read is issued.
- R8: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`. `rsp_valid` and the response fields hold steady until `rsp_ready`.
- R9: Changes to `req_va` or `root_ppn` after acceptance do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, can accept a request |
| req_va | input | 64 | Virtual address to translate |
| root_ppn | input | 40 | Page number of the top-level table |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Client accepts the result |
| rsp_pa | output | 52 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_noncanon | output | 1 | Failure due to bad sign extension |
| rsp_level | output | 2 | Level at which the walk failed |

## Verification
The hardest situations to reach are a clear present bit at each of the three lower levels. Reaching one needs a valid chain of upper entries that leads to a chosen hole. The bench builds a small sparse table tree, and some of its branches stop at a missing entry or at an entry present in number but absent in flag at the top, middle and last level. It drives addresses through every branch. Back-pressure is added on both memory and response handshakes, with varying read latency. The root and the request address are also scrambled right after acceptance, so that a walk which re-reads its inputs would go down a wrong branch.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned PW_ADDR_W  = 64;
  localparam int unsigned PW_VA_W    = 48;
  localparam int unsigned PW_PPN_W   = 40;
  localparam int unsigned PW_OFF_W   = 12;
  localparam int unsigned PW_IDX_W   = 9;
  localparam int unsigned PW_LEVELS  = 4;
  localparam int unsigned PW_ENTRY_B = 8;
  localparam int unsigned PW_DATA_W  = 64;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/pw_va_check.sv
module pw_va_check #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned VA_W   = 48
) (
  input  logic [ADDR_W-1:0] va,
  output logic              canonical
);
  localparam int unsigned TOP_W = ADDR_W - VA_W + 1;
  logic [TOP_W-1:0] top_bits;
  assign top_bits  = va[ADDR_W-1:VA_W-1];
  assign canonical = (&top_bits) | ~(|top_bits);
endmodule

// File: rtl/pw_index_sel.sv
module pw_index_sel #(
  parameter int unsigned VA_W   = 48,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned LEVELS = 4,
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] slice [LEVELS];
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign slice[g] = va[OFF_W + IDX_W*g +: IDX_W];
  end
  assign idx = slice[level];
endmodule

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
  parameter int unsigned PPN_W   = 40,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned ENTRY_B = 8,
  localparam int unsigned PA_W   = PPN_W + OFF_W,
  localparam int unsigned SHIFT  = $clog2(ENTRY_B)
) (
  input  logic [PPN_W-1:0] base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  addr
);
  logic [PA_W-1:0] base_byte;
  logic [PA_W-1:0] step;
  assign base_byte = {base, {OFF_W{1'b0}}};
  assign step      = PA_W'(idx) << SHIFT;
  assign addr      = base_byte + step;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
#(
  parameter int unsigned ADDR_W  = PW_ADDR_W,
  parameter int unsigned VA_W    = PW_VA_W,
  parameter int unsigned PPN_W   = PW_PPN_W,
  parameter int unsigned OFF_W   = PW_OFF_W,
  parameter int unsigned IDX_W   = PW_IDX_W,
  parameter int unsigned LEVELS  = PW_LEVELS,
  parameter int unsigned ENTRY_B = PW_ENTRY_B,
  parameter int unsigned DATA_W  = PW_DATA_W,
  localparam int unsigned PA_W   = PPN_W + OFF_W,
  localparam int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [PPN_W-1:0]  root_ppn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_fault,
  output logic              rsp_noncanon,
  output logic [LVL_W-1:0]  rsp_level
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  walk_state_e       state;
  logic [VA_W-1:0]   va_q;
  logic [PPN_W-1:0]  base_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              canon;
  logic [IDX_W-1:0]  cur_idx;
  logic [PA_W-1:0]   entry_addr;
  logic              ent_present;
  logic [PPN_W-1:0]  ent_ppn;

  pw_va_check #(.ADDR_W(ADDR_W), .VA_W(VA_W)) u_va_check (
    .va        (req_va),
    .canonical (canon)
  );

  pw_index_sel #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)) u_index_sel (
    .va    (va_q),
    .level (lvl_q),
    .idx   (cur_idx)
  );

  pw_entry_addr #(.PPN_W(PPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENTRY_B(ENTRY_B)) u_entry_addr (
    .base (base_q),
    .idx  (cur_idx),
    .addr (entry_addr)
  );

  assign ent_present   = mem_rsp_data[0];
  assign ent_ppn       = mem_rsp_data[OFF_W +: PPN_W];
  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_ISSUE);
  assign mem_req_addr  = entry_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      va_q         <= '0;
      base_q       <= '0;
      lvl_q        <= TOP_LVL;
      rsp_valid    <= 1'b0;
      rsp_pa       <= '0;
      rsp_fault    <= 1'b0;
      rsp_noncanon <= 1'b0;
      rsp_level    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_va[VA_W-1:0];
            base_q <= root_ppn;
            lvl_q  <= TOP_LVL;
            if (!canon) begin
              rsp_valid    <= 1'b1;
              rsp_pa       <= '0;
              rsp_fault    <= 1'b1;
              rsp_noncanon <= 1'b1;
              rsp_level    <= TOP_LVL;
              state        <= ST_RESP;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_present) begin
              rsp_valid    <= 1'b1;
              rsp_pa       <= '0;
              rsp_fault    <= 1'b1;
              rsp_noncanon <= 1'b0;
              rsp_level    <= lvl_q;
              state        <= ST_RESP;
            end else if (lvl_q == '0) begin
              rsp_valid    <= 1'b1;
              rsp_pa       <= {ent_ppn, va_q[OFF_W-1:0]};
              rsp_fault    <= 1'b0;
              rsp_noncanon <= 1'b0;
              rsp_level    <= '0;
              state        <= ST_RESP;
            end else begin
              base_q <= ent_ppn;
              lvl_q  <= lvl_q - 1'b1;
              state  <= ST_ISSUE;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int unsigned PA_W = 52
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_fault
);
  p_accept_drops_ready_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid && !rsp_valid);

  p_mem_hold_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault));

  p_busy_until_rsp_r1: assert property (@(posedge clk) disable iff (rst)
    !req_ready && !(rsp_valid && rsp_ready) |=> !req_ready);

  p_fault_zero_pa_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_pa == '0);
endmodule

bind pt_walker pw_checker #(.PA_W(PA_W)) u_pw_checker (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_pa        (rsp_pa),
  .rsp_fault     (rsp_fault)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [39:0] root_ppn = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [51:0] rsp_pa;
  logic        rsp_fault;
  logic        rsp_noncanon;
  logic [1:0]  rsp_level;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] pmem [logic [51:0]];

  always #4 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .root_ppn(root_ppn), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault), .rsp_noncanon(rsp_noncanon), .rsp_level(rsp_level)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [51:0] a);
    return pmem.exists(a) ? pmem[a] : 64'h0;
  endfunction

  function automatic logic [51:0] eaddr(input logic [39:0] base, input logic [8:0] idx);
    return {base, 12'h000} + {40'h0, idx, 3'b000};
  endfunction

  task automatic put(input logic [39:0] base, input logic [8:0] idx,
                     input logic [39:0] ppn, input bit present);
    pmem[eaddr(base, idx)] = {12'h000, ppn, 11'h000, present};
  endtask

  function automatic logic [63:0] mkva(input logic [8:0] a, input logic [8:0] b,
                                       input logic [8:0] c, input logic [8:0] d,
                                       input logic [11:0] off);
    logic [47:0] low;
    low = {a, b, c, d, off};
    return {{16{low[47]}}, low};
  endfunction

  task automatic do_walk(input logic [63:0] va, input int lat, input bit stall,
                         input int hold, input string name);
    logic [51:0] exp_a [$];
    logic [51:0] exp_pa = '0;
    bit          exp_f = 0, exp_nc = 0;
    logic [1:0]  exp_lv = 2'd0;
    logic [39:0] base, root_keep;
    int n = 0, cd = 0;
    bit pend = 0, stalled = 0, done = 0;
    int holdc = hold;
    logic [51:0] last = '0;
    root_keep = root_ppn;
    if (!((&va[63:47]) || !(|va[63:47]))) begin
      exp_f = 1; exp_nc = 1; exp_lv = 2'd3;
    end else begin
      base = root_ppn;
      for (int lv = 3; lv >= 0; lv--) begin
        logic [51:0] a;
        logic [63:0] e;
        a = eaddr(base, va[12 + 9*lv +: 9]);
        exp_a.push_back(a);
        e = rd(a);
        if (!e[0]) begin exp_f = 1; exp_lv = 2'(lv); break; end
        base = e[51:12];
      end
      if (!exp_f) exp_pa = {base, va[11:0]};
    end
    chk(req_ready === 1'b1, "R1", {name, " idle before request"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    req_va = ~va;
    root_ppn = root_ppn ^ 40'h00000005A5;
    for (int cyc = 0; cyc < 400 && !done; cyc++) begin
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      rsp_ready = 1'b0;
      if (req_ready !== 1'b0)
        chk(0, "R1", {name, " ready low while busy"}, 64'(req_ready), 64'd0);
      if (pend) begin
        if (cd == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = rd(last);
          pend = 0;
        end else cd--;
      end else if (mem_req_valid) begin
        if (stall && !stalled) begin
          stalled = 1;
        end else begin
          stalled = 0;
          mem_req_ready = 1'b1;
          if (n < exp_a.size())
            chk(mem_req_addr === exp_a[n], n == 0 ? "R2" : "R3",
                {name, " entry address"}, 64'(mem_req_addr), 64'(exp_a[n]));
          else
            chk(0, exp_nc ? "R6" : "R7", {name, " unexpected read"},
                64'(mem_req_addr), 64'h0);
          last = mem_req_addr;
          n++;
          pend = 1;
          cd = lat;
        end
      end
      if (rsp_valid) begin
        if (holdc > 0) holdc--;
        else begin
          rsp_ready = 1'b1;
          chk(rsp_fault === exp_f, exp_f ? "R7" : "R5", {name, " fault flag"},
              64'(rsp_fault), 64'(exp_f));
          chk(rsp_noncanon === exp_nc, "R6", {name, " noncanonical flag"},
              64'(rsp_noncanon), 64'(exp_nc));
          chk(rsp_pa === exp_pa, exp_f ? "R7" : "R5", {name, " physical address"},
              64'(rsp_pa), 64'(exp_pa));
          if (exp_f)
            chk(rsp_level === exp_lv, exp_nc ? "R6" : "R7", {name, " fault level"},
                64'(rsp_level), 64'(exp_lv));
          done = 1;
        end
      end
      @(negedge clk);
    end
    rsp_ready = 1'b0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    chk(done, "R8", {name, " response delivered"}, 64'(done), 64'd1);
    chk(n == exp_a.size(), exp_nc ? "R6" : "R3", {name, " read count"},
        64'(n), 64'(exp_a.size()));
    chk(req_ready === 1'b1, "R1", {name, " ready after response"}, 64'(req_ready), 64'd1);
    root_ppn = root_keep;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    root_ppn = 40'h0000000100;
    put(40'h100, 9'h0b9, 40'h042, 1);
    put(40'h042, 9'h00c, 40'h125, 1);
    put(40'h125, 9'h0ae, 40'h508, 1);
    put(40'h508, 9'h0c2, 40'hABCDE12345, 1);
    put(40'h508, 9'h0c3, 40'h0000000777, 1);
    put(40'h508, 9'h010, 40'h0000000333, 0);
    put(40'h100, 9'h1ff, 40'h200, 1);
    put(40'h200, 9'h000, 40'h201, 1);
    put(40'h201, 9'h1ff, 40'h202, 1);
    put(40'h202, 9'h1ff, 40'hFFFFFFFFFF, 1);
    put(40'h300, 9'h0b9, 40'h042, 1);
    put(40'h125, 9'h0af, 40'h600, 0);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
    chk(mem_req_valid === 1'b0, "R1", "reset no read", 64'(mem_req_valid), 64'd0);
    chk(rsp_valid === 1'b0, "R1", "reset no response", 64'(rsp_valid), 64'd0);

    do_walk(mkva(9'h0b9, 9'h00c, 9'h0ae, 9'h0c2, 12'h016), 0, 0, 0, "R5 basic walk");
    do_walk(mkva(9'h0b9, 9'h00c, 9'h0ae, 9'h0c3, 12'h103), 3, 1, 2, "R8 stalled walk");
    do_walk(mkva(9'h1ff, 9'h000, 9'h1ff, 9'h1ff, 12'hfff), 1, 0, 0, "R3 high half");
    do_walk(mkva(9'h0b9, 9'h00c, 9'h0ae, 9'h0c2, 12'h016) ^ 64'h0004_0000_0000_0000,
            0, 0, 0, "R6 bad upper bit");
    do_walk({16'h0000, 1'b1, 47'h0}, 0, 0, 1, "R6 missing extension");
    do_walk(mkva(9'h001, 9'h00c, 9'h0ae, 9'h0c2, 12'h0), 2, 0, 0, "R7 top absent");
    do_walk(mkva(9'h0b9, 9'h001, 9'h0ae, 9'h0c2, 12'h0), 0, 1, 0, "R7 level2 absent");
    do_walk(mkva(9'h0b9, 9'h00c, 9'h0af, 9'h0c2, 12'h0), 0, 0, 0, "R7 level1 absent");
    do_walk(mkva(9'h0b9, 9'h00c, 9'h0ae, 9'h010, 12'h0), 1, 1, 1, "R7 last absent");
    root_ppn = 40'h0000000300;
    do_walk(mkva(9'h0b9, 9'h00c, 9'h0ae, 9'h0c2, 12'h7a5), 2, 0, 0, "R9 other root");
    root_ppn = 40'h0000000100;
    do_walk(mkva(9'h0b9, 9'h00c, 9'h0ae, 9'h0c2, 12'h000), 0, 0, 3, "R4 offset zero");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule